// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration front end of a clock chip. It keeps three 28-bit working registers that drive the rest of the device, and it keeps a non-volatile shadow copy of the first two. A host talks to it over a four-wire serial port: a serial clock, a data-in line, an open-drain data-out line and a latch-enable line. Every command is one 32-bit frame framed by latch-enable low. A frame can write a working register, arm a read-back, or copy working registers 0 and 1 into the shadow store. The shadow store is a register array with a busy timer that models the long programming time of a real cell.

The serial lines and the power-down pin are oversampled by the system clock through two-flop synchronizers, so all logic runs in one clock domain. A controller state machine has four states. ST_DOWN holds the registers at zero while the power-down pin is low. ST_LOAD lasts one cycle and copies the shadow store into registers 0 and 1, and it returns register 2 to its default. ST_IDLE accepts frames. ST_STORE waits out the store timer and ignores the host.

The transitions are as follows. Reset goes to ST_LOAD. ST_LOAD goes to ST_IDLE. ST_IDLE goes to ST_STORE on an accepted copy command. ST_STORE goes to ST_IDLE when the timer expires. ST_DOWN goes to ST_LOAD when the power-down pin goes high. Any state goes to ST_DOWN while the power-down pin is low.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset, registers 0 and 1 hold the shadow defaults (DEF0, DEF1), register 2 holds DEF2 with its read-only fields overlaid, and spi_miso_oe is low.
- R2: A frame of exactly 32 bits, sent LSB first and sampled on rising serial clock edges, is decoded as follows: frame bits [3:0] are the address and bits [31:4] are the data. An address of 0, 1 or 2 writes the data into that register.
- R3: A frame is discarded unless exactly 32 rising clock edges occur while latch-enable is low. Edges seen while latch-enable is high are not counted, and frames of 31 or 33 bits change nothing.
- R4: A frame whose address field is 3 to 13 is discarded and changes no register.
- R5: Address 4'hE is a read. Data bits [1:0] (frame bits [5:4]) select register 0, 1 or 2, and code 3 reads as zero. During the next latch-enable low period, spi_miso_oe is high and spi_miso presents the selected value LSB first. Bit k is valid before the k-th rising edge, it changes after falling edges, and the 4 bits that follow the 28 data bits are zero.
- R6: Register 1 bit 27 always reads 0. Register 2 bit 6 follows the lock_in input. Register 2 bits 12:10 always read VERSION. Writes to these bits have no effect.
- R7: Address 4'hF copies registers 0 and 1 into the shadow store. For the next STORE_CYCLES clock cycles every frame is ignored, and after that time frames are accepted again.
- R8: While pd_n is low, all three registers read zero except for their read-only fields. When pd_n rises, registers 0 and 1 reload from the shadow store and register 2 returns to its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rst_n | input | 1 | Asynchronous power-on reset, active low; restores shadow defaults |
| pd_n | input | 1 | Power-down pin, active low; its rising edge reloads from the shadow store |
| lock_in | input | 1 | Lock status shown in register 2 bit 6 |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_le | input | 1 | Latch-enable; low frames a transfer |
| spi_miso | output | 1 | Serial read data value |
| spi_miso_oe | output | 1 | Open-drain enable for spi_miso |
| cfg_reg0 | output | 28 | Working register 0 |
| cfg_reg1 | output | 28 | Working register 1 |
| cfg_reg2 | output | 28 | Working register 2 with read-only fields |

## Verification
The bench drives frames of 31 and 33 bits, and it adds stray clock pulses while latch-enable is high. A design that counts edges loosely would accept a short frame or a long frame. Every address code is swept. A decoder that ignores the upper address bits would corrupt a register on an unused code. Read-back is checked bit by bit for every target, including the empty code, so a shifter that is off by one or an output enable that rises late shows up as wrong bits. The copy command is followed at once by a write, to catch a busy window that is missing or too short. A power-down pulse then checks that registers 0 and 1 return the stored values, not the factory defaults, and that register 2 does not come from the store.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
    localparam int FRAME_W   = 32;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = FRAME_W - ADDR_W;
    localparam int SEL_W     = 2;
    localparam int R1_RO_BIT = 27;
    localparam int R2_LOCK   = 6;
    localparam int R2_VER    = 10;
    localparam int VER_W     = 3;

    localparam logic [ADDR_W-1:0] CMD_READ  = 4'hE;
    localparam logic [ADDR_W-1:0] CMD_STORE = 4'hF;

    typedef enum logic [1:0] {
        ST_DOWN  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_IDLE  = 2'd2,
        ST_STORE = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } frame_t;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cfg_spi_rx.sv
module cfg_spi_rx
    import cfg_spi_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sclk,
    input  logic   mosi,
    input  logic   le,
    output logic   frame_vld,
    output frame_t frame
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic                 sclk_d;
    logic                 le_d;
    logic [FRAME_W-1:0]   shreg;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 sclk_rise;
    logic                 le_fall;
    logic                 le_rise;

    always_comb begin
        sclk_rise = sclk & ~sclk_d;
        le_fall   = ~le & le_d;
        le_rise   = le & ~le_d;
        frame     = frame_t'(shreg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            le_d      <= 1'b1;
            shreg     <= '0;
            bit_cnt   <= '0;
            frame_vld <= 1'b0;
        end else begin
            sclk_d    <= sclk;
            le_d      <= le;
            frame_vld <= le_rise && (bit_cnt == CNT_FULL);
            if (le_fall) begin
                bit_cnt <= '0;
            end else if (sclk_rise && !le && bit_cnt != CNT_OVER) begin
                shreg   <= {mosi, shreg[FRAME_W-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld); // R3
    AST_VLD_LE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> le); // R3
endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              le,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              miso,
    output logic              miso_oe
);
    logic              sclk_d;
    logic              le_d;
    logic              pend;
    logic              act;
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b1;
            pend   <= 1'b0;
            act    <= 1'b0;
            shreg  <= '0;
        end else begin
            sclk_d <= sclk;
            le_d   <= le;
            if (load) begin
                pend  <= 1'b1;
                shreg <= load_data;
            end else if (~le & le_d) begin
                act  <= pend;
                pend <= 1'b0;
            end else if (le & ~le_d) begin
                act <= 1'b0;
            end else if (act && ~sclk && sclk_d) begin
                shreg <= {1'b0, shreg[DATA_W-1:1]};
            end
        end
    end

    always_comb begin
        miso_oe = act;
        miso    = act & shreg[0];
    end

    AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && le) |=> !miso_oe); // R5
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> le); // R5
endmodule

// File: rtl/cfg_spi_nvm.sv
module cfg_spi_nvm
    import cfg_spi_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEF0         = '0,
    parameter logic [DATA_W-1:0] DEF1         = '0,
    parameter int                STORE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic [DATA_W-1:0] wr0,
    input  logic [DATA_W-1:0] wr1,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1,
    output logic              busy
);
    localparam int CNT_W = $clog2(STORE_CYCLES + 1);

    logic [CNT_W-1:0] tmr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd0 <= DEF0;
            rd1 <= DEF1;
            tmr <= '0;
        end else if (store) begin
            rd0 <= wr0;
            rd1 <= wr1;
            tmr <= CNT_W'(STORE_CYCLES);
        end else if (tmr != '0) begin
            tmr <= tmr - 1'b1;
        end
    end

    assign busy = (tmr != '0);

    AST_STORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> busy); // R7
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !store |=> ($stable(rd0) && $stable(rd1))); // R7
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
    import cfg_spi_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEF0         = 28'h1234567,
    parameter logic [DATA_W-1:0] DEF1         = 28'h0ABCDEF,
    parameter logic [DATA_W-1:0] DEF2         = 28'h5A50003,
    parameter logic [VER_W-1:0]  VERSION      = 3'd5,
    parameter int                STORE_CYCLES = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              lock_in,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_le,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [DATA_W-1:0] cfg_reg0,
    output logic [DATA_W-1:0] cfg_reg1,
    output logic [DATA_W-1:0] cfg_reg2
);
    localparam logic [DATA_W-1:0] WMASK1 = ~(DATA_W'(1) << R1_RO_BIT);
    localparam logic [DATA_W-1:0] WMASK2 =
        ~((DATA_W'(1) << R2_LOCK) | (DATA_W'((1 << VER_W) - 1) << R2_VER));

    logic              pd_s, le_s, mosi_s, sclk_s;
    logic              lock_q;
    logic              frame_vld;
    frame_t            fr;
    ctl_state_e        state, nxt;
    logic [DATA_W-1:0] wreg0, wreg1, wreg2;
    logic [DATA_W-1:0] view0, view1, view2;
    logic [DATA_W-1:0] nv_rd0, nv_rd1;
    logic              nv_busy;
    logic              acc, wr_en, rd_en, st_en;
    logic [DATA_W-1:0] rd_val;

    cfg_spi_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pd_n, spi_le, spi_mosi, spi_sclk}),
        .q     ({pd_s, le_s, mosi_s, sclk_s})
    );

    cfg_spi_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk_s),
        .mosi      (mosi_s),
        .le        (le_s),
        .frame_vld (frame_vld),
        .frame     (fr)
    );

    cfg_spi_nvm #(.DEF0(DEF0), .DEF1(DEF1), .STORE_CYCLES(STORE_CYCLES)) u_nvm (
        .clk   (clk),
        .rst_n (rst_n),
        .store (st_en),
        .wr0   (wreg0),
        .wr1   (wreg1),
        .rd0   (nv_rd0),
        .rd1   (nv_rd1),
        .busy  (nv_busy)
    );

    cfg_spi_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk_s),
        .le        (le_s),
        .load      (rd_en),
        .load_data (rd_val),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    // Command decode: only in ST_IDLE with power up.
    always_comb begin
        acc   = frame_vld && (state == ST_IDLE) && pd_s;
        wr_en = acc && (fr.addr < ADDR_W'(3));
        rd_en = acc && (fr.addr == CMD_READ);
        st_en = acc && (fr.addr == CMD_STORE);
        unique case (fr.data[SEL_W-1:0])
            2'd0:    rd_val = view0;
            2'd1:    rd_val = view1;
            2'd2:    rd_val = view2;
            default: rd_val = '0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_DOWN:  if (pd_s) nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_IDLE;
            ST_IDLE:  if (st_en) nxt = ST_STORE;
            ST_STORE: if (!nv_busy) nxt = ST_IDLE;
            default:  nxt = ST_DOWN;
        endcase
        if (!pd_s) nxt = ST_DOWN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wreg0  <= '0;
            wreg1  <= '0;
            wreg2  <= DEF2 & WMASK2;
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_in;
            if (state == ST_DOWN) begin
                wreg0 <= '0;
                wreg1 <= '0;
                wreg2 <= '0;
            end else if (state == ST_LOAD) begin
                wreg0 <= nv_rd0;
                wreg1 <= nv_rd1 & WMASK1;
                wreg2 <= DEF2 & WMASK2;
            end else if (wr_en) begin
                unique case (fr.addr[1:0])
                    2'd0:    wreg0 <= fr.data;
                    2'd1:    wreg1 <= fr.data & WMASK1;
                    default: wreg2 <= fr.data & WMASK2;
                endcase
            end
        end
    end

    // Output view with read-only fields overlaid.
    always_comb begin
        view0 = wreg0;
        view1 = wreg1;
        view1[R1_RO_BIT] = 1'b0;
        view2 = wreg2;
        view2[R2_LOCK] = lock_q;
        view2[R2_VER +: VER_W] = VERSION;
        cfg_reg0 = view0;
        cfg_reg1 = view1;
        cfg_reg2 = view2;
    end

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && pd_s) |=>
            ($stable(wreg0) && $stable(wreg1) && $stable(wreg2))); // R7
    AST_LOAD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state != ST_LOAD)); // R8
    AST_DOWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN) |=> (wreg0 == '0 && wreg1 == '0)); // R8
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && state != ST_IDLE) |=> $stable(wreg0)); // R7
endmodule

// File: tb/tb_cfg_spi_slave.sv
module tb_cfg_spi_slave;
    localparam int HALF = 6;
    localparam int STC  = 3000;
    localparam logic [27:0] D0 = 28'h1234567;
    localparam logic [27:0] D1 = 28'h0ABCDEF;
    localparam logic [27:0] D2 = 28'h5A50003;
    localparam logic [2:0]  VER = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pd_n = 1'b1, lock_in = 1'b0;
    logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_le = 1'b1;
    logic spi_miso, spi_miso_oe;
    logic [27:0] cfg_reg0, cfg_reg1, cfg_reg2;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [27:0] m0, m1, m2;
    logic [31:0] rdbits;
    logic oe_ok;

    always #10 clk = ~clk;

    cfg_spi_slave #(.DEF0(D0), .DEF1(D1), .DEF2(D2), .VERSION(VER),
                    .STORE_CYCLES(STC)) dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .lock_in(lock_in),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_le(spi_le),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .cfg_reg0(cfg_reg0), .cfg_reg1(cfg_reg1), .cfg_reg2(cfg_reg2)
    );

    function automatic logic [27:0] v1(input logic [27:0] s);
        logic [27:0] r = s;
        r[27] = 1'b0;
        return r;
    endfunction

    function automatic logic [27:0] v2(input logic [27:0] s, input logic lk);
        logic [27:0] r = s;
        r[6] = lk;
        r[12:10] = VER;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, {4'h0, cfg_reg0}, {4'h0, m0});
        chk(req, {4'h0, cfg_reg1}, {4'h0, v1(m1)});
        chk(req, {4'h0, cfg_reg2}, {4'h0, v2(m2, lock_in)});
    endtask

    task automatic frame(input logic [31:0] f, input int nbits);
        rdbits = '0;
        oe_ok  = 1'b1;
        @(negedge clk);
        spi_le = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = f[i % 32];
            repeat (HALF) @(negedge clk);
            if (i < 32) rdbits[i] = spi_miso;
            if (!spi_miso_oe) oe_ok = 1'b0;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_le = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [27:0] d);
        frame({d, a}, 32);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        m0 = D0; m1 = D1; m2 = D2;
        // R1 reset state
        chk_regs("R1");
        chk("R1 oe", {31'h0, spi_miso_oe}, 32'h0);

        // R2 write sweep
        for (int a = 0; a < 3; a++) begin
            for (int p = 0; p < 4; p++) begin
                logic [27:0] d;
                d = (p == 0) ? 28'h0000001 : (p == 1) ? 28'hFFFFFFF :
                    (p == 2) ? 28'hA5A5A5A : (28'h1 << (a * 9 + p));
                wr(4'(a), d);
                if (a == 0) m0 = d; else if (a == 1) m1 = d; else m2 = d;
                chk_regs("R2");
            end
        end

        // R5 read sweep including empty code 3
        for (int t = 0; t < 4; t++) begin
            logic [27:0] ev;
            ev = (t == 0) ? m0 : (t == 1) ? v1(m1) : (t == 2) ? v2(m2, lock_in) : 28'h0;
            frame({26'h0, 2'(t), 4'hE}, 32);
            frame({28'h0, 4'h5}, 32);
            chk("R5 data", rdbits, {4'h0, ev});
            chk("R5 oe", {31'h0, oe_ok}, 32'h1);
            chk("R5 oe after", {31'h0, spi_miso_oe}, 32'h0);
        end

        // R3 short, long, and edges while latch-enable high
        frame({28'hBEEF123, 4'h0}, 31);
        chk_regs("R3 short");
        frame({28'hBEEF123, 4'h0}, 33);
        chk_regs("R3 long");
        for (int k = 0; k < 3; k++) begin
            spi_sclk = 1'b1; repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0; repeat (HALF) @(negedge clk);
        end
        frame({28'hBEEF123, 4'h1}, 31);
        chk_regs("R3 le high edges");

        // R4 unused address codes
        for (int a = 3; a < 14; a++) begin
            wr(4'(a), 28'h7777777);
            chk_regs("R4");
        end

        // R6 read-only fields
        lock_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 lock", {31'h0, cfg_reg2[6]}, 32'h1);
        wr(4'd2, 28'h0000000);
        m2 = 28'h0;
        chk("R6 ver", {4'h0, cfg_reg2}, {4'h0, v2(28'h0, 1'b1)});
        wr(4'd1, 28'hFFFFFFF);
        m1 = 28'hFFFFFFF;
        chk("R6 bit27", {4'h0, cfg_reg1}, 32'h07FFFFFF);
        lock_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 unlock", {31'h0, cfg_reg2[6]}, 32'h0);

        // R7 store and busy window
        wr(4'd0, 28'h1111111); m0 = 28'h1111111;
        wr(4'd1, 28'h2222222); m1 = 28'h2222222;
        wr(4'd2, 28'h3333333); m2 = 28'h3333333;
        frame({28'h0, 4'hF}, 32);
        wr(4'd0, 28'h9999999);
        chk_regs("R7 busy ignore");
        repeat (STC) @(negedge clk);
        wr(4'd0, 28'h4444444); m0 = 28'h4444444;
        chk_regs("R7 after busy");

        // R8 power-down and reload from shadow
        pd_n = 1'b0;
        repeat (10) @(negedge clk);
        m0 = '0; m1 = '0; m2 = '0;
        chk_regs("R8 down");
        pd_n = 1'b1;
        repeat (10) @(negedge clk);
        m0 = 28'h1111111; m1 = 28'h2222222; m2 = D2;
        chk_regs("R8 reload");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule